// File: doc/BRIEF.md
# Multi-mode quadrature position counter

This block turns a pair of already-filtered quadrature encoder phases into a signed position count. A two-bit mode input picks how edges are counted. Two modes are bidirectional: two edges or four edges per encoder cycle, with the sign taken from the phase relationship. Two modes are forward-only: phase B is ignored and the count can only grow, by one or two per cycle. A separate control inverts phase A before decoding, which reverses the sign of counted motion.

An external registration strobe is brought into the clock domain and, on its rising edge, copies the position into a capture register. A single-cycle valid pulse marks each capture. The position counter is `POS_W` bits wide (32 by default) and wraps in two's complement.

Top module: `quad_pos_counter`

## Requirements
- R1: While reset is asserted and in the first cycles after it is released, the position output, the captured value and the capture-valid output are all zero.
- R2: In mode 2'b01 every single edge on A or B moves the position by exactly one. Forward motion, meaning the (A,B) sequence 00, 10, 11, 01, 00, increments it, and the reverse sequence decrements it. One full forward cycle therefore adds four counts.
- R3: In mode 2'b01, a sample in which A and B have both changed since the previous sample leaves the position unchanged.
- R4: In mode 2'b00 only edges of A are counted. The count goes up when A after the edge differs from B, and down when they are equal. Edges of B alone never change the position.
- R5: In mode 2'b10 only a rising edge of A adds one. Falling edges of A and all edges of B have no effect, and the position never decreases.
- R6: In mode 2'b11 every edge of A, rising or falling, adds one. Edges of B are ignored.
- R7: When the direction-invert input is 1, phase A is complemented before decoding. In 4x mode this turns forward motion into down-counting, and in the 1x mode it counts falling edges of the physical A. Toggling the invert input alone does not change the position.
- R8: The first input sample after reset only records the phase levels. Whatever A and B are at that moment, no count is produced.
- R9: The position wraps modulo 2^POS_W. A forward step from the largest positive value gives the most negative value, and a reverse step from zero gives all ones.
- R10: A rising edge of the strobe passes through a two-stage synchronizer. Two clock edges after the rising strobe is first sampled, the current position is copied to the capture output and the valid output is 1 for exactly one cycle. The captured value then holds until the next capture, and a strobe held high produces a single capture.
- R11: An input sample is reflected in the position output right after the same clock edge that samples it. The position does not change while A and B stay constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| enc_a_i | input | 1 | Filtered phase A, synchronous to clk_i |
| enc_b_i | input | 1 | Filtered phase B, synchronous to clk_i |
| mode_i | input | 2 | Count mode: 00 bidirectional 2x, 01 bidirectional 4x, 10 forward 1x, 11 forward 2x |
| dir_inv_i | input | 1 | 1 complements phase A before decoding |
| strobe_i | input | 1 | Asynchronous registration strobe |
| pos_o | output | POS_W | Signed position count |
| cap_pos_o | output | POS_W | Position captured at the last strobe rising edge |
| cap_valid_o | output | 1 | One-cycle pulse marking a new capture |

## Verification
A phase change driven before clock edge k is counted at edge k, so the bench samples the position one time unit after that same edge, after every single step. A strobe first seen at edge k produces the capture and the valid pulse just after edge k+2. The bench checks that valid is still low after edges k and k+1, high after k+2 and low again after k+3. Tests that expect no effect look at the position after each ignored edge before driving the next one. The wrap case runs a second, 8-bit instance on the same inputs so the overflow boundary is reached in a few hundred cycles.

// File: rtl/qpc_pkg.sv
package qpc_pkg;

    typedef enum logic [1:0] {
        MODE_BI2X  = 2'b00,
        MODE_BI4X  = 2'b01,
        MODE_FWD1X = 2'b10,
        MODE_FWD2X = 2'b11
    } count_mode_e;

    typedef enum logic [1:0] {
        STEP_NONE = 2'b00,
        STEP_UP   = 2'b01,
        STEP_DOWN = 2'b10
    } step_e;

endpackage

// File: rtl/qpc_edge_decode.sv
module qpc_edge_decode
    import qpc_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        a_i,
    input  logic        b_i,
    input  logic        inv_i,
    input  count_mode_e mode_i,
    output step_e       step_o
);

    typedef struct packed {
        logic prev_a;
        logic prev_b;
        logic primed;
    } dec_state_t;

    dec_state_t st_d, st_q;

    logic       a_new, a_old, a_edge;
    logic [1:0] idx_new, idx_old, idx_diff;
    step_e      step_d;

    always_comb begin
        // Inversion is applied to both the new and the stored sample, so
        // toggling inv_i alone never looks like an edge.
        a_new    = a_i ^ inv_i;
        a_old    = st_q.prev_a ^ inv_i;
        a_edge   = a_new ^ a_old;
        idx_new  = {b_i, a_new ^ b_i};
        idx_old  = {st_q.prev_b, a_old ^ st_q.prev_b};
        idx_diff = idx_new - idx_old;
        step_d   = STEP_NONE;

        unique case (mode_i)
            MODE_BI2X: begin
                if (a_edge) step_d = (a_new != b_i) ? STEP_UP : STEP_DOWN;
            end
            MODE_BI4X: begin
                if (idx_diff == 2'd1)      step_d = STEP_UP;
                else if (idx_diff == 2'd3) step_d = STEP_DOWN;
            end
            MODE_FWD1X: begin
                if (a_edge && a_new) step_d = STEP_UP;
            end
            MODE_FWD2X: begin
                if (a_edge) step_d = STEP_UP;
            end
            default: step_d = STEP_NONE;
        endcase

        if (!st_q.primed) step_d = STEP_NONE;

        st_d.prev_a = a_i;
        st_d.prev_b = b_i;
        st_d.primed = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign step_o = step_d;

endmodule

// File: rtl/qpc_pos_accum.sv
module qpc_pos_accum
    import qpc_pkg::*;
#(
    parameter int POS_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  step_e            step_i,
    output logic [POS_W-1:0] pos_o
);

    localparam logic [POS_W-1:0] ONE = POS_W'(1);

    typedef struct packed {
        logic [POS_W-1:0] pos;
    } acc_state_t;

    acc_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (step_i)
            STEP_UP:   st_d.pos = st_q.pos + ONE;
            STEP_DOWN: st_d.pos = st_q.pos - ONE;
            default:   st_d.pos = st_q.pos;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign pos_o = st_q.pos;

    // A single sample moves the count by at most one, with wrap.
    assert_unit_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (pos_o == $past(pos_o) || pos_o == $past(pos_o) + ONE ||
                  pos_o == $past(pos_o) - ONE));

endmodule

// File: rtl/qpc_reg_latch.sv
module qpc_reg_latch #(
    parameter int POS_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             strobe_i,
    input  logic [POS_W-1:0] pos_i,
    output logic [POS_W-1:0] cap_pos_o,
    output logic             cap_valid_o
);

    localparam int CHAIN_W = SYNC_STAGES + 1;

    typedef struct packed {
        logic [CHAIN_W-1:0] chain;
        logic [POS_W-1:0]   cap;
        logic               valid;
    } lat_state_t;

    lat_state_t st_d, st_q;
    logic       rise;

    always_comb begin
        st_d       = st_q;
        // chain[SYNC_STAGES-1] is the synchronized strobe, chain[SYNC_STAGES]
        // its previous value for edge detection.
        st_d.chain = {st_q.chain[CHAIN_W-2:0], strobe_i};
        rise       = st_q.chain[SYNC_STAGES-1] & ~st_q.chain[SYNC_STAGES];
        st_d.valid = rise;
        if (rise) st_d.cap = pos_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign cap_pos_o   = st_q.cap;
    assign cap_valid_o = st_q.valid;

    assert_valid_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cap_valid_o |=> !cap_valid_o);

    assert_capture_value_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cap_valid_o |-> cap_pos_o == $past(pos_i));

    assert_capture_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cap_valid_o |-> $stable(cap_pos_o));

endmodule

// File: rtl/quad_pos_counter.sv
module quad_pos_counter
    import qpc_pkg::*;
#(
    parameter int POS_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             enc_a_i,
    input  logic             enc_b_i,
    input  logic [1:0]       mode_i,
    input  logic             dir_inv_i,
    input  logic             strobe_i,
    output logic [POS_W-1:0] pos_o,
    output logic [POS_W-1:0] cap_pos_o,
    output logic             cap_valid_o
);

    localparam logic [POS_W-1:0] ONE = POS_W'(1);

    step_e       step;
    count_mode_e mode;
    logic [POS_W-1:0] pos;

    assign mode = count_mode_e'(mode_i);

    qpc_edge_decode u_decode (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .a_i    (enc_a_i),
        .b_i    (enc_b_i),
        .inv_i  (dir_inv_i),
        .mode_i (mode),
        .step_o (step)
    );

    qpc_pos_accum #(.POS_W(POS_W)) u_accum (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .step_i (step),
        .pos_o  (pos)
    );

    qpc_reg_latch #(.POS_W(POS_W), .SYNC_STAGES(SYNC_STAGES)) u_latch (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .strobe_i    (strobe_i),
        .pos_i       (pos),
        .cap_pos_o   (cap_pos_o),
        .cap_valid_o (cap_valid_o)
    );

    assign pos_o = pos;

    assert_invalid_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == 2'b01 && enc_a_i != $past(enc_a_i) && enc_b_i != $past(enc_b_i))
        |=> $stable(pos_o));

    assert_fwd_only_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mode_i[1] |=> (pos_o == $past(pos_o) || pos_o == $past(pos_o) + ONE));

    assert_idle_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($stable(enc_a_i) && $stable(enc_b_i)) |=> $stable(pos_o));

    assert_reset_zero_R1: assert property (@(posedge clk_i)
        !rst_ni |-> (pos_o == '0 && !cap_valid_o));

endmodule

// File: tb/quad_pos_counter_tb.sv
`timescale 1ns/1ps
module quad_pos_counter_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enc_a = 1'b1, enc_b = 1'b1;
    logic [1:0]  mode = 2'b01;
    logic        inv = 1'b0;
    logic        strobe = 1'b0;
    logic [31:0] pos, cap;
    logic        cap_v;
    logic [7:0]  pos8, cap8;
    logic        cap_v8;

    int          n_cmp = 0;
    int          n_bad = 0;
    logic [31:0] exp_pos = '0;

    always #2.5 clk = ~clk;

    quad_pos_counter dut_i (
        .clk_i(clk), .rst_ni(rst_n), .enc_a_i(enc_a), .enc_b_i(enc_b),
        .mode_i(mode), .dir_inv_i(inv), .strobe_i(strobe),
        .pos_o(pos), .cap_pos_o(cap), .cap_valid_o(cap_v)
    );

    quad_pos_counter #(.POS_W(8)) dut_w8_i (
        .clk_i(clk), .rst_ni(rst_n), .enc_a_i(enc_a), .enc_b_i(enc_b),
        .mode_i(mode), .dir_inv_i(inv), .strobe_i(strobe),
        .pos_o(pos8), .cap_pos_o(cap8), .cap_valid_o(cap_v8)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic mv(input logic a, input logic b, input int delta, input string tag);
        @(negedge clk);
        enc_a = a; enc_b = b;
        tick();
        exp_pos = exp_pos + 32'(delta);
        chk(tag, pos, exp_pos);
    endtask

    task automatic set_cfg(input logic [1:0] m, input logic iv, input string tag);
        @(negedge clk);
        mode = m; inv = iv;
        tick();
        chk(tag, pos, exp_pos);
    endtask

    task automatic fwd_step();
        logic na, nb;
        case ({enc_a, enc_b})
            2'b00:   begin na = 1'b1; nb = 1'b0; end
            2'b10:   begin na = 1'b1; nb = 1'b1; end
            2'b11:   begin na = 1'b0; nb = 1'b1; end
            default: begin na = 1'b0; nb = 1'b0; end
        endcase
        @(negedge clk);
        enc_a = na; enc_b = nb;
        tick();
        exp_pos = exp_pos + 32'd1;
    endtask

    task automatic t_reset();
        repeat (4) @(posedge clk);
        #1;
        chk("R1 pos in reset", pos, 32'd0);
        chk("R1 valid in reset", {31'd0, cap_v}, 32'd0);
        @(negedge clk); rst_n = 1'b1;
        repeat (3) tick();
        chk("R8 no count on first sample (A=B=1)", pos, 32'd0);
        chk("R1 capture after reset", cap, 32'd0);
        chk("R1 valid after reset", {31'd0, cap_v}, 32'd0);
    endtask

    task automatic t_4x();
        mv(1'b0, 1'b1, 1, "R11 4x 11->01 same-edge update");
        mv(1'b0, 1'b0, 1, "R2 4x 01->00");
        mv(1'b1, 1'b0, 1, "R2 4x fwd 00->10");
        mv(1'b1, 1'b1, 1, "R2 4x fwd 10->11");
        mv(1'b0, 1'b1, 1, "R2 4x fwd 11->01");
        mv(1'b0, 1'b0, 1, "R2 4x fwd 01->00");
        repeat (3) tick();
        chk("R11 constant inputs hold", pos, exp_pos);
        mv(1'b0, 1'b1, -1, "R2 4x rev 00->01");
        mv(1'b1, 1'b1, -1, "R2 4x rev 01->11");
        mv(1'b1, 1'b0, -1, "R2 4x rev 11->10");
        mv(1'b0, 1'b0, -1, "R2 4x rev 10->00");
        mv(1'b1, 1'b1, 0, "R3 4x 00->11 ignored");
        mv(1'b0, 1'b0, 0, "R3 4x 11->00 ignored");
    endtask

    task automatic t_2x_bi();
        set_cfg(2'b00, 1'b0, "R4 mode change no count");
        mv(1'b1, 1'b0, 1, "R4 A rise B=0 up");
        mv(1'b1, 1'b1, 0, "R4 B edge ignored");
        mv(1'b0, 1'b1, 1, "R4 A fall B=1 up");
        mv(1'b0, 1'b0, 0, "R4 B edge ignored");
        mv(1'b0, 1'b1, 0, "R4 B edge ignored");
        mv(1'b1, 1'b1, -1, "R4 A rise B=1 down");
        mv(1'b1, 1'b0, 0, "R4 B edge ignored");
        mv(1'b0, 1'b0, -1, "R4 A fall B=0 down");
    endtask

    task automatic t_1x();
        set_cfg(2'b10, 1'b0, "R5 mode change no count");
        mv(1'b1, 1'b0, 1, "R5 A rise up");
        mv(1'b1, 1'b1, 0, "R5 B ignored");
        mv(1'b0, 1'b1, 0, "R5 A fall ignored");
        mv(1'b0, 1'b0, 0, "R5 B ignored");
        mv(1'b0, 1'b1, 0, "R5 B ignored");
        mv(1'b1, 1'b1, 1, "R5 reverse-order A rise still up");
        mv(1'b1, 1'b0, 0, "R5 B ignored");
        mv(1'b0, 1'b0, 0, "R5 A fall ignored");
    endtask

    task automatic t_2x_fwd();
        set_cfg(2'b11, 1'b0, "R6 mode change no count");
        mv(1'b1, 1'b0, 1, "R6 A rise up");
        mv(1'b0, 1'b0, 1, "R6 A fall up");
        mv(1'b0, 1'b1, 0, "R6 B ignored");
        mv(1'b1, 1'b1, 1, "R6 A rise up");
        mv(1'b0, 1'b1, 1, "R6 A fall up");
        mv(1'b0, 1'b0, 0, "R6 B ignored");
    endtask

    task automatic t_invert();
        set_cfg(2'b01, 1'b1, "R7 invert toggle no count");
        mv(1'b1, 1'b0, -1, "R7 inverted fwd counts down");
        mv(1'b1, 1'b1, -1, "R7 inverted fwd counts down");
        mv(1'b0, 1'b1, -1, "R7 inverted fwd counts down");
        mv(1'b0, 1'b0, -1, "R7 inverted fwd counts down");
        set_cfg(2'b10, 1'b1, "R7 mode change no count");
        mv(1'b1, 1'b0, 0, "R7 1x inverted: physical A rise ignored");
        mv(1'b0, 1'b0, 1, "R7 1x inverted: physical A fall counts");
        set_cfg(2'b01, 1'b0, "R7 invert release no count");
    endtask

    task automatic t_latch();
        logic [31:0] held;
        @(negedge clk); strobe = 1'b1;
        tick();
        chk("R10 no valid at sample edge", {31'd0, cap_v}, 32'd0);
        @(negedge clk); strobe = 1'b0;
        tick();
        chk("R10 no valid after first sync stage", {31'd0, cap_v}, 32'd0);
        tick();
        chk("R10 valid two edges later", {31'd0, cap_v}, 32'd1);
        chk("R10 captured position", cap, exp_pos);
        held = exp_pos;
        tick();
        chk("R10 valid lasts one cycle", {31'd0, cap_v}, 32'd0);
        mv(1'b1, 1'b0, 1, "R2 move after capture");
        mv(1'b1, 1'b1, 1, "R2 move after capture");
        chk("R10 capture holds", cap, held);
        // reverse to below zero: now at 11, exp = held + 2
        mv(1'b1, 1'b0, -1, "R2 rev");
        mv(1'b0, 1'b0, -1, "R2 rev");
        for (int i = 0; i < 32'(held) + 1; i++) begin
            case ({enc_a, enc_b})
                2'b00:   mv(1'b0, 1'b1, -1, "R2 rev");
                2'b01:   mv(1'b1, 1'b1, -1, "R2 rev");
                2'b11:   mv(1'b1, 1'b0, -1, "R2 rev");
                default: mv(1'b0, 1'b0, -1, "R2 rev");
            endcase
        end
        chk("R9 reverse through zero gives all ones", pos, 32'hFFFF_FFFF);
        @(negedge clk); strobe = 1'b1;
        tick(); tick(); tick();
        chk("R10 capture of negative value", cap, 32'hFFFF_FFFF);
        chk("R10 valid on held strobe", {31'd0, cap_v}, 32'd1);
        repeat (4) tick();
        chk("R10 held strobe gives single pulse", {31'd0, cap_v}, 32'd0);
        @(negedge clk); strobe = 1'b0;
        tick();
    endtask

    task automatic t_wrap();
        logic [7:0] n;
        n = 8'h7f - exp_pos[7:0];
        for (int i = 0; i < int'(n); i++) fwd_step();
        chk("R9 8-bit at max positive", {24'd0, pos8}, 32'h7f);
        fwd_step();
        chk("R9 8-bit wraps to most negative", {24'd0, pos8}, 32'h80);
        chk("R9 32-bit continues", pos, exp_pos);
    endtask

    initial begin
        #(5.0 * 100000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_4x();
        t_2x_bi();
        t_1x();
        t_2x_fwd();
        t_invert();
        t_latch();
        t_wrap();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule